// File: doc/BRIEF.md
# AGC Post-Shutdown Boost Timer

This block supervises the digital side of a charge-pump automatic gain control loop in a receiver that is switched on and off to save power. While the receiver is held in shutdown, the block turns both pump directions off so the external hold capacitor floats and keeps its voltage. When shutdown is released, it raises the pump current for a fixed window counted in reference clock cycles. This lets the loop quickly make up any droop that built up while the capacitor was floating.

Outside shutdown, the block turns a single comparison bit (detected level above target) into an up or down pump enable. It also reports the current scale in force, 1 normally and 45 during the boost window. Finally, it gives the pump magnitude in unit currents, with the fixed asymmetry that the pull-down (attack) direction is ten times the pull-up (decay) direction. The window length is a cycle count, so its duration in time varies inversely with the reference frequency. The analog current sources and the capacitor are outside this block.

Top module: `agc_boost_supervisor`

## Requirements
- R1: While reset is applied (synchronous, active high) the outputs are float_hold=1, pump_up=0, pump_dn=0, boost=0, i_scale=1, pump_mag=0.
- R2: A clock edge that samples shutdown=1 makes float_hold=1 and pump_up=pump_dn=0 and pump_mag=0 from that edge on, whatever level_hi is.
- R3: A clock edge that samples shutdown=0 makes pump_dn=1, pump_up=0 if level_hi=1, and pump_up=1, pump_dn=0 if level_hi=0, with float_hold=0.
- R4: A release is an edge that samples shutdown=0 while the block is in the shutdown state (including the state left by reset). The release sets boost=1 at that edge, and boost stays high for exactly BOOST_LEN clock cycles (default 65536).
- R5: An edge that samples shutdown=1 during a boost window clears boost at that edge. The next release starts a fresh window of the full BOOST_LEN cycles.
- R6: While shutdown stays low, boost never rises again after a window ends, however level_hi moves.
- R7: i_scale is 45 while boost=1 and 1 otherwise.
- R8: pump_mag equals the direction weight times i_scale, with weight 1 for pump_up, 10 for pump_dn and 0 when neither is enabled. The only values it takes are 0, 1, 10, 45 and 450.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; times the boost window |
| rst | input | 1 | Synchronous active-high reset |
| shutdown | input | 1 | High holds the receiver in shutdown |
| level_hi | input | 1 | Detected level is above the gain target |
| pump_up | output | 1 | Enable for the pull-up (decay) current |
| pump_dn | output | 1 | Enable for the pull-down (attack) current |
| boost | output | 1 | Boost window active |
| float_hold | output | 1 | Hold capacitor left floating |
| i_scale | output | 6 | Current multiplier code, 1 or 45 |
| pump_mag | output | 9 | Active pump current in unit currents |

## Verification
The bench measures the boost window cycle by cycle at its full default length, twice. An off-by-one in the counter load or the end test would show up as a window of 65535 or 65537 cycles. It re-asserts shutdown in the middle of a window to catch a timer that keeps running through shutdown, and a timer that resumes the old count instead of reloading on the next release. After a window ends, it toggles the level input with shutdown held low, which exposes a design that starts a boost on a level change rather than only on release. It also checks the four non-zero magnitudes, which a swapped ratio or a scale applied to only one direction would get wrong.

// File: rtl/agc_sup_pkg.sv
package agc_sup_pkg;

    // Relative pump strengths in unit currents
    localparam int unsigned UP_UNITS   = 1;
    localparam int unsigned DN_UNITS   = 10;
    localparam int unsigned BOOST_GAIN = 45;

    localparam int unsigned SCALE_W = $clog2(BOOST_GAIN + 1);
    localparam int unsigned MAG_W   = $clog2(DN_UNITS * BOOST_GAIN + 1);

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DN   = 2'b10
    } pump_dir_e;

    typedef struct packed {
        logic      float_hold;
        pump_dir_e dir;
    } pump_state_t;

    function automatic logic [SCALE_W-1:0] scale_of(input logic boost_on);
        return boost_on ? SCALE_W'(BOOST_GAIN) : SCALE_W'(1);
    endfunction

    function automatic logic [MAG_W-1:0] mag_of(input pump_dir_e d,
                                                 input logic [SCALE_W-1:0] s);
        logic [MAG_W-1:0] w;
        case (d)
            DIR_UP:  w = MAG_W'(UP_UNITS);
            DIR_DN:  w = MAG_W'(DN_UNITS);
            default: w = '0;
        endcase
        return MAG_W'(w * MAG_W'(s));
    endfunction

endpackage

// File: rtl/agc_shut_edge.sv
module agc_shut_edge (
    input  logic clk,
    input  logic rst,
    input  logic shutdown,
    output logic shut_q,
    output logic release_p
);
    // Reset leaves the block as if shut down
    always_ff @(posedge clk) begin
        if (rst) shut_q <= 1'b1;
        else     shut_q <= shutdown;
    end

    assign release_p = shut_q & ~shutdown;

    // R2: sampled shutdown is remembered at the next edge
    a_r2_shut_tracked: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> shut_q);

endmodule

// File: rtl/agc_boost_timer.sv
module agc_boost_timer #(
    parameter int unsigned BOOST_LEN = 65536,
    parameter int unsigned CNT_W     = $clog2(BOOST_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic boost_q
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BOOST_LEN - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            boost_q <= 1'b0;
            cnt     <= '0;
        end else if (stop) begin
            boost_q <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            boost_q <= 1'b1;
            cnt     <= LOAD;
        end else if (boost_q) begin
            if (cnt == '0) boost_q <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    // R4: a release opens the window
    a_r4_start_opens: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> boost_q);

    // R4: window stays open while count remains
    a_r4_window_holds: assert property (@(posedge clk) disable iff (rst)
        (boost_q && !stop && !start && cnt != '0) |=> boost_q);

    // R5: shutdown closes the window
    a_r5_stop_closes: assert property (@(posedge clk) disable iff (rst)
        stop |=> !boost_q);

    // R6: no window without a release
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!boost_q && !start) |=> !boost_q);

endmodule

// File: rtl/agc_pump_ctrl.sv
module agc_pump_ctrl
    import agc_sup_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        shutdown,
    input  logic        level_hi,
    output pump_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.float_hold <= 1'b1;
            st.dir        <= DIR_HOLD;
        end else begin
            st.float_hold <= shutdown;
            if (shutdown)      st.dir <= DIR_HOLD;
            else if (level_hi) st.dir <= DIR_DN;
            else               st.dir <= DIR_UP;
        end
    end

    // R3: above target selects the attack direction
    a_r3_attack_dir: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && level_hi) |=> st.dir == DIR_DN);

    // R3: below target selects the decay direction
    a_r3_decay_dir: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && !level_hi) |=> st.dir == DIR_UP);

endmodule

// File: rtl/agc_boost_supervisor.sv
module agc_boost_supervisor
    import agc_sup_pkg::*;
#(
    parameter int unsigned BOOST_LEN = 65536,
    parameter int unsigned CNT_W     = $clog2(BOOST_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shutdown,
    input  logic               level_hi,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               boost,
    output logic               float_hold,
    output logic [SCALE_W-1:0] i_scale,
    output logic [MAG_W-1:0]   pump_mag
);
    logic        shut_q;
    logic        release_p;
    pump_state_t st;

    agc_shut_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .shutdown  (shutdown),
        .shut_q    (shut_q),
        .release_p (release_p)
    );

    agc_boost_timer #(
        .BOOST_LEN (BOOST_LEN),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (release_p),
        .stop    (shutdown),
        .boost_q (boost)
    );

    agc_pump_ctrl u_pump (
        .clk      (clk),
        .rst      (rst),
        .shutdown (shutdown),
        .level_hi (level_hi),
        .st       (st)
    );

    assign float_hold = st.float_hold;
    assign pump_up    = (st.dir == DIR_UP);
    assign pump_dn    = (st.dir == DIR_DN);
    assign i_scale    = scale_of(boost);
    assign pump_mag   = mag_of(st.dir, i_scale);

    // R2: a floating capacitor sees no pump current
    a_r2_float_no_pump: assert property (@(posedge clk) disable iff (rst)
        float_hold |-> (!pump_up && !pump_dn && pump_mag == '0));

    // R4: leaving the floating state raises the boost (edge tracker vs pump state)
    a_r4_release_boosts: assert property (@(posedge clk) disable iff (rst)
        (float_hold && !shutdown) |=> boost);

    // R5: boost never coexists with the floating state
    a_r5_no_boost_floating: assert property (@(posedge clk) disable iff (rst)
        float_hold |-> !boost);

    // R8: at most one direction, and idle means zero magnitude
    a_r8_one_direction: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pump_up, pump_dn}) && ((pump_up || pump_dn) || pump_mag == '0));

endmodule

// File: tb/sim_agc_boost_supervisor.sv
`timescale 1ns/1ps
module sim_agc_boost_supervisor;
    import agc_sup_pkg::*;

    localparam int L = 65536;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shutdown = 1'b1;
    logic level_hi = 1'b0;
    logic pump_up, pump_dn, boost, float_hold;
    logic [SCALE_W-1:0] i_scale;
    logic [MAG_W-1:0]   pump_mag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    agc_boost_supervisor #(.BOOST_LEN(L)) u0 (
        .clk(clk), .rst(rst), .shutdown(shutdown), .level_hi(level_hi),
        .pump_up(pump_up), .pump_dn(pump_dn), .boost(boost),
        .float_hold(float_hold), .i_scale(i_scale), .pump_mag(pump_mag)
    );

    // {shutdown, level_hi, exp float, exp up, exp dn, exp boost, exp mag[8:0]}
    localparam logic [14:0] VEC [8] = '{
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'd45},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'd450},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'd45},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'd450},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic count_boost(output int n);
        n = 0;
        while (boost && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        bit seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "float_hold", int'(float_hold), 1);
        chk("R1", "pump_up", int'(pump_up), 0);
        chk("R1", "pump_dn", int'(pump_dn), 0);
        chk("R1", "boost", int'(boost), 0);
        chk("R1", "i_scale", int'(i_scale), 1);
        chk("R1", "pump_mag", int'(pump_mag), 0);
        rst = 1'b0;
        @(negedge clk);

        // Vector walk: R2, R3, R4, R5, R7, R8 under mixed patterns
        for (int i = 0; i < 8; i++) begin
            shutdown = VEC[i][14];
            level_hi = VEC[i][13];
            @(negedge clk);
            chk("R2", $sformatf("vec%0d float", i), int'(float_hold), int'(VEC[i][12]));
            chk("R3", $sformatf("vec%0d up", i), int'(pump_up), int'(VEC[i][11]));
            chk("R3", $sformatf("vec%0d dn", i), int'(pump_dn), int'(VEC[i][10]));
            chk("R5", $sformatf("vec%0d boost", i), int'(boost), int'(VEC[i][9]));
            chk("R7", $sformatf("vec%0d scale", i), int'(i_scale), VEC[i][9] ? 45 : 1);
            chk("R8", $sformatf("vec%0d mag", i), int'(pump_mag), int'(VEC[i][8:0]));
        end

        // R4: full window length from a release
        shutdown = 1'b0;
        level_hi = 1'b0;
        @(negedge clk);
        count_boost(n);
        chk("R4", "window length", n, L);
        chk("R7", "scale after window", int'(i_scale), 1);
        chk("R8", "up magnitude unboosted", int'(pump_mag), 1);
        level_hi = 1'b1;
        @(negedge clk);
        chk("R8", "down magnitude unboosted", int'(pump_mag), 10);
        chk("R3", "down enable", int'(pump_dn), 1);

        // R6: level activity with shutdown low never restarts the boost
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            level_hi = k[0] ^ k[2];
            @(negedge clk);
            if (boost) seen = 1'b1;
        end
        chk("R6", "boost during level toggles", int'(seen), 0);

        // R5: abort mid-window, then a fresh full window
        shutdown = 1'b1;
        @(negedge clk);
        shutdown = 1'b0;
        level_hi = 1'b1;
        @(negedge clk);
        repeat (100) @(negedge clk);
        chk("R4", "boost mid-window", int'(boost), 1);
        shutdown = 1'b1;
        @(negedge clk);
        chk("R5", "boost after re-shutdown", int'(boost), 0);
        chk("R2", "float after re-shutdown", int'(float_hold), 1);
        chk("R2", "mag after re-shutdown", int'(pump_mag), 0);
        shutdown = 1'b0;
        @(negedge clk);
        chk("R8", "down magnitude boosted", int'(pump_mag), 450);
        count_boost(n);
        chk("R5", "fresh window length", n, L);

        // R1 again mid-run, then release straight out of reset (R4)
        rst = 1'b1;
        shutdown = 1'b0;
        level_hi = 1'b1;
        @(negedge clk);
        chk("R1", "float in reset", int'(float_hold), 1);
        chk("R1", "dn in reset", int'(pump_dn), 0);
        chk("R1", "mag in reset", int'(pump_mag), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R4", "boost after reset release", int'(boost), 1);
        chk("R8", "mag after reset release", int'(pump_mag), 450);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule